// File: doc/BRIEF.md
# Fractional Timebase Prescaler

This block produces a free-running 64-bit timebase that many consumers on a chip can read. It advances from one of two input tick strobes: a strobe from the crystal oscillator domain, whose nominal rate is 19.2 MHz, or a strobe from the core clock domain. The rate is not set by an integer divide. It is set by a 32-bit prescaler value that gives the ratio as a fraction of 2^31.

Each selected tick adds the effective prescaler value to a 31-bit phase. The timebase steps whenever that phase crosses 2^31. The output rate is therefore the input tick rate times the prescaler value divided by 2^31. A value of 0x80000000 gives one step per tick. A control register chooses the tick source and chooses whether each step adds 1 or 2 to the timebase. Both registers are written and read through a small synchronous register port.

Top module: `lt_prescaler`

## Requirements
- R1: After reset, the control register, the prescaler, the phase and the timebase are all 0. Reading address 0 or address 1 returns 0.
- R2: Address 0 holds the control register. Only bit 8 (source) and bit 9 (step size) are stored, and every other bit reads back as 0. Address 1 holds the prescaler, and all 32 bits read back as written. A write to address 2 or 3 changes nothing, and a read from those addresses returns 0.
- R3: When control bit 8 is 0, only `tick_xtal` advances the timebase. When bit 8 is 1, only `tick_core` advances it. The unselected strobe has no effect.
- R4: When control bit 9 is 0, each step adds 1 to the timebase. When bit 9 is 1, each step adds 2.
- R5: Each selected tick adds the effective prescaler value P to the phase. After N ticks from a zero phase, the number of steps taken is floor(N*P/2^31).
- R6: A prescaler value of 0x80000000 makes exactly one step on every selected tick.
- R7: A prescaler value above 0x80000000 behaves exactly like 0x80000000, so no tick ever makes more than one step.
- R8: While the prescaler value is 0, the timebase does not advance.
- R9: A selected tick that is high in a cycle updates the timebase at that cycle's rising clock edge. A register write takes effect only for ticks in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 2 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| tick_xtal | input | 1 | Crystal-domain tick strobe, synchronous to clk |
| tick_core | input | 1 | Core-domain tick strobe, synchronous to clk |
| timebase | output | 64 | Timebase counter |

## Verification
The assertions assume three things about the inputs. The tick strobes are already synchronous to `clk`. Reset is held long enough to clear every register. The timebase never wraps within a run, so its difference from one cycle to the next is always 0, 1 or 2.

The stimulus stays within these assumptions in three ways. It drives ticks and writes at the falling edge only. It applies reset before every case. It runs each case for at most a few dozen ticks, which keeps the timebase far below its wrap point.

// File: rtl/lt_prescaler.sv
module lt_prescaler #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 2,
  parameter int CNT_W    = 64,
  parameter int SRC_BIT  = 8,
  parameter int STEP_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_xtal,
  input  logic              tick_core,
  output logic [CNT_W-1:0]  timebase
);
  localparam int FRAC_W = DATA_W - 1;
  localparam logic [DATA_W-1:0] UNITY = DATA_W'(1) << FRAC_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] PRE_ADDR  = ADDR_W'(1);

  logic              src_core, step_two;
  logic [DATA_W-1:0] pre;
  logic [FRAC_W-1:0] phase;

  wire              sel_tick = src_core ? tick_core : tick_xtal;
  wire [DATA_W-1:0] pre_eff  = (pre > UNITY) ? UNITY : pre;
  wire [DATA_W-1:0] sum      = {1'b0, phase} + pre_eff;
  wire              carry    = sum[DATA_W-1];
  wire [CNT_W-1:0]  inc      = step_two ? CNT_W'(2) : CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_core <= 1'b0;
      step_two <= 1'b0;
      pre      <= '0;
      phase    <= '0;
      timebase <= '0;
    end else begin
      if (reg_we && reg_waddr == CTRL_ADDR) begin
        src_core <= reg_wdata[SRC_BIT];
        step_two <= reg_wdata[STEP_BIT];
      end
      if (reg_we && reg_waddr == PRE_ADDR)
        pre <= reg_wdata;
      if (sel_tick) begin
        phase <= sum[FRAC_W-1:0];
        if (carry)
          timebase <= timebase + inc;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == CTRL_ADDR) begin
      reg_rdata[SRC_BIT]  = src_core;
      reg_rdata[STEP_BIT] = step_two;
    end else if (reg_raddr == PRE_ADDR) begin
      reg_rdata = pre;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) $rose(rst_n) |-> timebase == '0);

  a_r4_step_size: assert property (@(posedge clk) disable iff (!rst_n)
    (timebase != $past(timebase)) |->
      (timebase - $past(timebase) == ($past(step_two) ? CNT_W'(2) : CNT_W'(1))));

  a_r8_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pre == '0) |=> $stable(timebase));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_xtal && !tick_core) |=> $stable(timebase));
endmodule

// File: tb/sim_lt_prescaler.sv
`timescale 1ns/1ps
module sim_lt_prescaler;
  logic        clk = 0, rst_n = 0, reg_we = 0, tick_xtal = 0, tick_core = 0;
  logic [1:0]  reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [63:0] timebase;
  int errors = 0, checks = 0;
  bit done = 0;

  lt_prescaler u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .tick_xtal(tick_xtal), .tick_core(tick_core), .timebase(timebase));

  always #5 clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick_xtal = 0; tick_core = 0; reg_we = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic run_case(int src, int stp, logic [31:0] p, int n, string req);
    logic [63:0] peff, exp;
    do_reset();
    wr(2'd0, (32'(src) << 8) | (32'(stp) << 9));
    wr(2'd1, p);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (src == 1) begin tick_core = 1; tick_xtal = i[0]; end
      else begin tick_xtal = 1; tick_core = i[0]; end
      @(negedge clk);
      if (src == 1) begin tick_core = 0; tick_xtal = 1; end
      else begin tick_xtal = 0; tick_core = 1; end
    end
    @(negedge clk); tick_xtal = 0; tick_core = 0;
    peff = (p > 32'h80000000) ? 64'h80000000 : {32'd0, p};
    exp  = ((64'(n) * peff) >> 31) * 64'(stp + 1);
    chk(req, timebase, exp);
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] plist [8] = '{32'h80000000, 32'h40000000, 32'h60000000, 32'h55555555,
                               32'h12345678, 32'h00000001, 32'hFFFFFFFF, 32'h80000001};
    do_reset();
    chk("R1 timebase", timebase, 0);
    rd(2'd0, d); chk("R1 ctrl", {32'd0, d}, 0);
    rd(2'd1, d); chk("R1 pre", {32'd0, d}, 0);

    wr(2'd0, 32'hFFFFFFFF); rd(2'd0, d); chk("R2 ctrl mask", {32'd0, d}, 64'h300);
    wr(2'd1, 32'hFFFFFFFF); rd(2'd1, d); chk("R2 pre readback", {32'd0, d}, 64'hFFFFFFFF);
    wr(2'd2, 32'h0); wr(2'd3, 32'h0);
    rd(2'd0, d); chk("R2 unmapped write ctrl", {32'd0, d}, 64'h300);
    rd(2'd1, d); chk("R2 unmapped write pre", {32'd0, d}, 64'hFFFFFFFF);
    rd(2'd2, d); chk("R2 unmapped read", {32'd0, d}, 0);

    do_reset();
    wr(2'd0, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); tick_xtal = 1; tick_core = 1;
    end
    @(negedge clk); tick_xtal = 0; tick_core = 0;
    chk("R8 zero prescaler holds", timebase, 0);

    do_reset();
    wr(2'd0, 0);
    @(negedge clk); tick_xtal = 1; reg_we = 1; reg_waddr = 2'd1; reg_wdata = 32'h80000000;
    @(negedge clk); reg_we = 0;
    chk("R9 write not used same cycle", timebase, 0);
    @(negedge clk); tick_xtal = 0;
    chk("R9 step at tick edge", timebase, 1);
    @(negedge clk);
    chk("R9 hold without tick", timebase, 1);

    run_case(0, 0, 32'h80000000, 25, "R6 unity xtal");
    run_case(1, 1, 32'h80000000, 25, "R6 unity core step2");
    run_case(0, 0, 32'hFFFFFFFF, 30, "R7 saturate");
    run_case(1, 0, 32'h80000001, 30, "R7 just above unity");
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 2; k++)
        for (int p = 0; p < 8; p++)
          run_case(s, k, plist[p], 37, $sformatf("R5 R3 R4 src=%0d step2=%0d p=%h", s, k, plist[p]));
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500us;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule